// File: doc/BRIEF.md
# Queue-to-Core Load Sequencer

This block stands between a word queue and a processing core that consumes data in narrower pieces or on a fixed schedule. It pops one wide word from the queue, holds it in a register, and feeds it to the core through a per-state sequence. Each state picks one slice of the held word and decides whether the load strobe is raised in that cycle.

Two feed styles are chosen by parameter. In passive style the sequencer runs on its own through `N_STATES` states per word. The load strobe in each state comes from a parameter mask, so the same logic serves a core that needs one strobe per fixed-length block and a core that takes one narrow slice every cycle. In active style the core asks for each slice with a read strobe, and the block answers one cycle later with the slice and a one-cycle load pulse.

Input and output widths are parameters. The number of slices is the input width divided by the output width. Slices are issued starting from the least significant one.

Top module: `lds_load_sequencer`

## Requirements
- R1: In passive style, when the sequencer is idle, `en` is 1 and `q_empty` is 0, `q_pop` is 1 in that same cycle. In the next cycle the first state begins with `core_load` at 1 and `core_data` equal to bits `OUT_W-1:0` of the popped word.
- R2: State k drives bits `[k*OUT_W +: OUT_W]` of the held word for k below `IN_W/OUT_W`, and the top slice for later states. With the default 40-bit input and 8-bit output, the slices appear in bits 7:0, 15:8, 23:16, 31:24 and 39:32 over 5 consecutive cycles.
- R3: In passive style, `core_load` in state k equals bit k of `LOAD_MASK`. The default mask `5'b11111` raises the load strobe in all five states, so a word is never interrupted.
- R4: With `IN_W=OUT_W=128`, `N_STATES=12` and `LOAD_MASK=1`, `core_load` is 1 only in the first of the 12 states. `core_data` shows the whole word in all 12 states.
- R5: If `en` is 1 and the queue is not empty in the last state, `q_pop` is 1 in that state. The next cycle is state 0 of the new word, with no gap, and every queued word is delivered in order.
- R6: If no word can be popped when a sequence ends, the sequencer goes idle. While idle, `core_load` is 0, `core_data` is 0, and old data is not repeated.
- R7: While `en` is 0, no new sequence starts and `q_pop` stays 0. A sequence already under way runs to its last state.
- R8: In active style, a cycle with `core_rd` at 1 and a slice left in the held word is answered in the next cycle: `core_load` is 1 for one cycle and `core_data` shows the next slice. When no slice is left, or the sequencer is idle, `q_pop` is 1 in the same cycle as `core_rd` (given `en` and data) and slice 0 of the new word follows. Between reads the last slice stays on `core_data` with `core_load` at 0.
- R9: In active style, a read with nothing left to give pops nothing. It gives `core_load` 0 in the next cycle, and the sequencer drops to idle with `core_data` 0.
- R10: In passive style, `core_rd` has no effect on any output.
- R11: While the synchronous active-high `rst` is 1, `q_pop` and `core_load` are 0. After the edge on which `rst` is sampled high, the sequencer is idle with `core_data` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; gates the start of each new word |
| q_data | input | IN_W | Word at the head of the queue |
| q_empty | input | 1 | Queue holds no word |
| q_pop | output | 1 | Removes the head word at the next edge; combinational |
| core_rd | input | 1 | Core request for the next slice (active style only) |
| core_data | output | OUT_W | Slice presented to the core |
| core_load | output | 1 | Load strobe to the core |

## Verification
`q_pop` is combinational, so it is sampled just after the falling edge of the same cycle in which the enable, the queue state or the read strobe is driven. `core_load` and `core_data` come from state registers, so the first slice is due at the falling edge one cycle after the pop, and each later state is due one cycle after the one before. The bench drives all inputs just after a falling edge and samples 1 ns later, so every expected value is tied to a counted edge. A random phase feeds a scoreboard that predicts the next slice from the pushed words. The scoreboard also requires a load exactly one cycle after each pop and an unbroken run of loads within a word.

// File: rtl/lds_pkg.sv
package lds_pkg;

    // Upper bound on states per word; sets the width of the step counter.
    localparam int MAX_STATES = 32;
    localparam int STEP_W     = $clog2(MAX_STATES);

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic {
        FEED_PASSIVE = 1'b0,
        FEED_ACTIVE  = 1'b1
    } feed_mode_e;

    // Sequencer state carried between the controller and the datapath.
    typedef struct packed {
        logic  busy;   // a word is held and being issued
        step_t step;   // current state index within the word
        logic  ack;    // active style: a read was answered last cycle
    } seq_state_t;

    // Slice chosen for a given step: steps past the last slice keep the top one.
    function automatic step_t slice_pick(input step_t s, input int slices);
        if (int'(s) >= slices) return step_t'(slices - 1);
        return s;
    endfunction

    // Index of the final state of a word for the chosen feed style.
    function automatic step_t final_step(input feed_mode_e m, input int n_states,
                                         input int slices);
        if (m == FEED_PASSIVE) return step_t'(n_states - 1);
        return step_t'(slices - 1);
    endfunction

endpackage

// File: rtl/lds_seq_ctrl.sv
module lds_seq_ctrl
    import lds_pkg::*;
#(
    parameter feed_mode_e MODE     = FEED_PASSIVE,
    parameter int         N_STATES = 5,
    parameter int         SLICES   = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       q_empty,
    input  logic       core_rd,
    output logic       pop,
    output seq_state_t st
);

    localparam step_t LAST = final_step(MODE, N_STATES, SLICES);

    seq_state_t nxt;
    logic       at_end;
    logic       avail;
    logic       advance;

    assign at_end  = !st.busy || (st.step == LAST);
    assign avail   = en && !q_empty;
    // Passive style steps every cycle; active style steps only on a read.
    assign advance = (MODE == FEED_PASSIVE) ? 1'b1 : core_rd;
    assign pop     = !rst && advance && at_end && avail;

    always_comb begin
        nxt     = st;
        nxt.ack = 1'b0;
        if (advance) begin
            if (pop) begin
                nxt.busy = 1'b1;
                nxt.step = '0;
                nxt.ack  = 1'b1;
            end else if (!at_end) begin
                nxt.step = st.step + step_t'(1);
                nxt.ack  = 1'b1;
            end else begin
                nxt.busy = 1'b0;
                nxt.step = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    // R11: reset leaves the sequencer idle
    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (!st.busy && !st.ack && st.step == '0));

    // R3: the step counter never passes the final state
    p_step_bound_r3: assert property (@(posedge clk) disable iff (rst)
        st.step <= LAST);

    // R1: a pop always opens state 0 of a held word
    p_pop_opens_r1: assert property (@(posedge clk) disable iff (rst)
        pop |=> (st.busy && st.step == '0));

    if (MODE == FEED_PASSIVE) begin : g_passive_chk
        // R7: a word under way advances one state per cycle regardless of en
        p_run_on_r7: assert property (@(posedge clk) disable iff (rst)
            (st.busy && st.step != LAST) |=>
                (st.busy && st.step == $past(st.step) + step_t'(1)));
    end else begin : g_active_chk
        // R8: an answer is only given to a read
        p_ack_needs_rd_r8: assert property (@(posedge clk) disable iff (rst)
            st.ack |-> $past(core_rd));
    end

endmodule

// File: rtl/lds_word_reg.sv
module lds_word_reg #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R2: the held word only changes on a pop
    p_word_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> $stable(q));

endmodule

// File: rtl/lds_slice_mux.sv
module lds_slice_mux
    import lds_pkg::*;
#(
    parameter int IN_W  = 40,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  word,
    input  step_t            sel,
    output logic [OUT_W-1:0] slice
);

    localparam int SLICES = IN_W / OUT_W;

    logic [OUT_W-1:0] parts [SLICES];
    step_t            pick;

    for (genvar i = 0; i < SLICES; i++) begin : g_part
        assign parts[i] = word[i*OUT_W +: OUT_W];
    end

    assign pick = slice_pick(sel, SLICES);

    always_comb begin
        slice = '0;
        for (int i = 0; i < SLICES; i++) begin
            if (pick == step_t'(i)) slice = parts[i];
        end
    end

endmodule

// File: rtl/lds_load_sequencer.sv
module lds_load_sequencer
    import lds_pkg::*;
#(
    parameter int                    IN_W      = 40,
    parameter int                    OUT_W     = 8,
    parameter int                    N_STATES  = 5,
    parameter logic [MAX_STATES-1:0] LOAD_MASK = 32'h0000_001F,
    parameter feed_mode_e            MODE      = FEED_PASSIVE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [IN_W-1:0]  q_data,
    input  logic             q_empty,
    output logic             q_pop,
    input  logic             core_rd,
    output logic [OUT_W-1:0] core_data,
    output logic             core_load
);

    localparam int SLICES = IN_W / OUT_W;

    if ((IN_W % OUT_W) != 0 || SLICES > MAX_STATES || N_STATES > MAX_STATES ||
        (MODE == FEED_PASSIVE && N_STATES < SLICES)) begin : g_bad_cfg
        $error("lds_load_sequencer: unsupported width or state count");
    end

    seq_state_t       st;
    logic [IN_W-1:0]  word;
    logic [OUT_W-1:0] slice;
    logic             mask_bit;

    lds_seq_ctrl #(
        .MODE     (MODE),
        .N_STATES (N_STATES),
        .SLICES   (SLICES)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .q_empty (q_empty),
        .core_rd (core_rd),
        .pop     (q_pop),
        .st      (st)
    );

    lds_word_reg #(
        .W (IN_W)
    ) u_word (
        .clk  (clk),
        .rst  (rst),
        .load (q_pop),
        .d    (q_data),
        .q    (word)
    );

    lds_slice_mux #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W)
    ) u_mux (
        .word  (word),
        .sel   (st.step),
        .slice (slice)
    );

    assign mask_bit  = LOAD_MASK[st.step];
    assign core_data = st.busy ? slice : '0;
    assign core_load = (MODE == FEED_PASSIVE) ? (st.busy && mask_bit) : st.ack;

    // R6: leaving a word with nothing queued shows neither strobe nor data
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(st.busy) |-> (!core_load && core_data == '0));

    if (MODE == FEED_ACTIVE || LOAD_MASK[0]) begin : g_first_load
        // R1: the cycle after a pop always strobes the core
        p_load_after_pop_r1: assert property (@(posedge clk) disable iff (rst)
            q_pop |=> core_load);
    end

endmodule

// File: tb/lds_load_sequencer_tb.sv
module lds_tb_queue #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] data,
    output logic         empty
);
    logic [W-1:0] mem [256];
    logic [7:0]   head;
    logic [7:0]   tail;

    assign data  = mem[head];
    assign empty = (head == tail);

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (push) begin
                mem[tail] <= push_data;
                tail      <= tail + 8'd1;
            end
            if (pop && !empty) head <= head + 8'd1;
        end
    end
endmodule

module lds_load_sequencer_tb;
    import lds_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic qrst = 1'b1;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // narrow passive instance (defaults)
    logic        n_en = 1'b0, n_rd = 1'b0, n_push = 1'b0;
    logic [39:0] n_pdata = '0, n_qdata;
    logic        n_empty, n_pop, n_load;
    logic [7:0]  n_data;

    // wide passive instance
    logic         w_en = 1'b0, w_push = 1'b0;
    logic [127:0] w_pdata = '0, w_qdata;
    logic         w_empty, w_pop, w_load;
    logic [127:0] w_data;

    // narrow active instance
    logic        a_en = 1'b0, a_rd = 1'b0, a_push = 1'b0;
    logic [39:0] a_pdata = '0, a_qdata;
    logic        a_empty, a_pop, a_load;
    logic [7:0]  a_data;

    lds_tb_queue #(.W(40)) u_q_n (.clk(clk), .rst(qrst), .push(n_push), .push_data(n_pdata),
        .pop(n_pop), .data(n_qdata), .empty(n_empty));
    lds_tb_queue #(.W(128)) u_q_w (.clk(clk), .rst(qrst), .push(w_push), .push_data(w_pdata),
        .pop(w_pop), .data(w_qdata), .empty(w_empty));
    lds_tb_queue #(.W(40)) u_q_a (.clk(clk), .rst(qrst), .push(a_push), .push_data(a_pdata),
        .pop(a_pop), .data(a_qdata), .empty(a_empty));

    lds_load_sequencer u_dut (
        .clk(clk), .rst(rst), .en(n_en), .q_data(n_qdata), .q_empty(n_empty),
        .q_pop(n_pop), .core_rd(n_rd), .core_data(n_data), .core_load(n_load));

    lds_load_sequencer #(.IN_W(128), .OUT_W(128), .N_STATES(12),
        .LOAD_MASK(32'h0000_0001), .MODE(FEED_PASSIVE)) u_dut_wide (
        .clk(clk), .rst(rst), .en(w_en), .q_data(w_qdata), .q_empty(w_empty),
        .q_pop(w_pop), .core_rd(1'b0), .core_data(w_data), .core_load(w_load));

    lds_load_sequencer #(.IN_W(40), .OUT_W(8), .N_STATES(5),
        .LOAD_MASK(32'h0000_001F), .MODE(FEED_ACTIVE)) u_dut_act (
        .clk(clk), .rst(rst), .en(a_en), .q_data(a_qdata), .q_empty(a_empty),
        .q_pop(a_pop), .core_rd(a_rd), .core_data(a_data), .core_load(a_load));

    function automatic logic [7:0] slc(input logic [39:0] w, input int k);
        return w[k*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_n(input logic [39:0] d);
        n_push = 1'b1; n_pdata = d; @(negedge clk); n_push = 1'b0;
    endtask
    task automatic push_w(input logic [127:0] d);
        w_push = 1'b1; w_pdata = d; @(negedge clk); w_push = 1'b0;
    endtask
    task automatic push_a(input logic [39:0] d);
        a_push = 1'b1; a_pdata = d; @(negedge clk); a_push = 1'b0;
    endtask

    task automatic rd_step(input logic ep, input logic el, input logic [7:0] ed, input string req);
        a_rd = 1'b1; #1;
        chk({req, " pop"}, a_pop, ep);
        @(negedge clk); a_rd = 1'b0; #1;
        chk({req, " load"}, a_load, el);
        chk({req, " data"}, a_data, ed);
    endtask

    // Scoreboard for the random phase of the narrow passive instance
    logic [39:0] exp_q [1024];
    int  np = 0, wi = 0, kk = 0;
    logic prev_pop = 1'b0;
    bit   mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            #1;
            if (prev_pop) chk("R1/R5 load after pop", n_load, 1'b1);
            if (n_load) begin
                if (kk == 0) chk("R5 word start follows pop", prev_pop, 1'b1);
                chk("R2/R10 slice order", n_data, slc(exp_q[wi], kk));
                kk++;
                if (kk == 5) begin kk = 0; wi++; end
            end else begin
                chk("R3/R7 unbroken word", kk, 0);
                chk("R6 idle data", n_data, 8'h00);
            end
            prev_pop = n_pop;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [39:0]  w0;
        logic [127:0] wa, wb;
        logic [39:0]  a0, a1;
        void'($urandom(32'd2024));
        w0 = 40'hA1_B2_C3_D4_E5;

        repeat (3) @(negedge clk);
        qrst = 1'b0;
        n_en = 1'b1;
        // R11: queue holds data and enable is on, yet reset blocks everything
        push_n(w0);
        #1;
        chk("R11 pop in reset", n_pop, 1'b0);
        chk("R11 load in reset", n_load, 1'b0);
        chk("R11 data in reset", n_data, 8'h00);
        @(negedge clk); #1;
        chk("R11 pop in reset", n_pop, 1'b0);

        // R7: enable low keeps the word queued
        n_en = 1'b0; rst = 1'b0;
        w_en = 1'b1; a_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R7 no pop while disabled", n_pop, 1'b0);
            chk("R7 no load while disabled", n_load, 1'b0);
        end

        // R1: start in the same cycle enable rises
        n_en = 1'b1; #1;
        chk("R1 pop on start", n_pop, 1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            chk("R3 load in each state", n_load, 1'b1);
            chk("R2 slice lsb first", n_data, slc(w0, k));
            if (k == 4) chk("R6 no pop when empty", n_pop, 1'b0);
        end
        @(negedge clk); #1;
        chk("R6 idle load", n_load, 1'b0);
        chk("R6 idle data not repeated", n_data, 8'h00);
        chk("R6 idle pop", n_pop, 1'b0);

        // R4/R5: wide single-slice schedule, back to back
        wa = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        wb = 128'hDEAD_BEEF_0BAD_F00D_1357_9BDF_2468_ACE0;
        push_w(wa);
        push_w(wb);
        for (int s = 0; s < 12; s++) begin
            #1;
            chk("R4 load only in first state", w_load, (s == 0));
            chk("R4 full word held", w_data, wa);
            if (s == 11) chk("R5 pop in last state", w_pop, 1'b1);
            @(negedge clk);
        end
        for (int s = 0; s < 12; s++) begin
            #1;
            chk("R4/R5 second word", w_load, (s == 0));
            chk("R4 second word data", w_data, wb);
            if (s == 11) chk("R6 wide no pop when empty", w_pop, 1'b0);
            @(negedge clk);
        end
        #1;
        chk("R6 wide idle load", w_load, 1'b0);
        chk("R6 wide idle data", w_data, 128'h0);

        // R8/R9: active style
        a0 = 40'h55_44_33_22_11;
        a1 = 40'h9F_8E_7D_6C_5B;
        rd_step(1'b0, 1'b0, 8'h00, "R9 read on empty");
        push_a(a0);
        push_a(a1);
        rd_step(1'b1, 1'b1, slc(a0, 0), "R8 first read");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R8 no read no load", a_load, 1'b0);
            chk("R8 slice held", a_data, slc(a0, 0));
        end
        for (int k = 1; k < 5; k++) rd_step(1'b0, 1'b1, slc(a0, k), "R8 next slice");
        rd_step(1'b1, 1'b1, slc(a1, 0), "R8 next word");
        for (int k = 1; k < 5; k++) rd_step(1'b0, 1'b1, slc(a1, k), "R8 next slice");
        rd_step(1'b0, 1'b0, 8'h00, "R9 exhausted read");

        // Random phase on the narrow passive instance
        @(negedge clk);
        rst = 1'b1; qrst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; qrst = 1'b0;
        mon_on = 1'b1;
        for (int c = 0; c < 3000; c++) begin
            logic [63:0] r;
            n_en = (($urandom % 8) != 0);
            n_rd = $urandom % 2;
            if ((c < 40 && (c % 2) == 0) || ($urandom % 8) == 0) begin
                r = {$urandom, $urandom};
                n_push = 1'b1; n_pdata = r[39:0];
                exp_q[np] = r[39:0]; np++;
            end else begin
                n_push = 1'b0;
            end
            @(negedge clk);
        end
        n_push = 1'b0; n_en = 1'b1; n_rd = 1'b0;
        repeat (600) @(negedge clk);
        mon_on = 1'b0;
        #2;
        chk("R5 all words delivered", wi, np);
        chk("R5 no partial word", kk, 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule